// File: doc/BRIEF.md
# Centralized Scoreboard Issue Controller

This block tracks hazards centrally for a floating-point pipeline that issues in order and executes out of order. The pipeline has eight architectural registers and three functional units: add, multiply and divide. Each cycle it looks at one decoded instruction, given as a unit class, an operation code, a destination and two sources. It either grants issue or reports a stall. While the front end sees a stall it holds the same instruction, so issue stays in program order.

Each instruction then passes through three more gated steps. The controller tells a unit when its operands may be read from the register file. It takes a completion pulse from the unit. It then grants or withholds the right to write the result back. Two tables carry all the state: one entry per functional unit and one result-status entry per register. No value is ever forwarded. A consumer sees a result only through the register file, and only after that result has been written back.

Top module: `sb_ctrl`

## Requirements
- R1: `issue_ok` is high in a cycle exactly when `in_valid` is high, the unit selected by `in_cls` is idle, and no active instruction has `in_dst` as its destination. `issue_stall` is high exactly when `in_valid` is high and `issue_ok` is low.
- R2: A destination that is already pending blocks issue (write-after-write), even when the selected unit is idle.
- R3: Class encoding on `in_cls` is 0 for add (unit 0), 1 for multiply (unit 1) and 2 for divide (unit 2). Code 3 never issues.
- R4: `rd_go[u]` is high while unit u holds an instruction that has not yet read and both of its sources are ready. A source is ready at issue if no active instruction writes it, or if its writer is granted write-back in that same cycle.
- R5: Each instruction reads its operands exactly once. A later instruction may read before an earlier one.
- R6: `done[u]` is accepted only while unit u is executing, meaning it has read its operands and not yet completed. A pulse at any other time has no effect.
- R7: A completed unit is denied write-back while another unit that has not yet read still holds the same register as a ready source (write-after-read). A unit that is waiting for this result does not block it.
- R8: Write-back of unit w makes every source waiting on w ready. The earliest a waiting consumer can read is the cycle after the write grant.
- R9: At most one `wr_go` bit is high per cycle. Among units that may write, unit 0 wins over unit 1, and unit 1 wins over unit 2.
- R10: A write grant frees its unit and its destination register from the next cycle on. An instruction that needs either one is not granted in the same cycle as that write.
- R11: `fu_op` carries, in bits [3u+2:3u], the operation code that was issued to unit u, and it holds that code while the unit is busy.
- R12: While reset is high and in the cycle after it, every unit is idle: no `rd_go` or `wr_go`, and issue depends only on R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Functional unit class (R3) |
| in_op | input | 3 | Operation code for the unit |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| issue_ok | output | 1 | Instruction issues this cycle |
| issue_stall | output | 1 | Instruction present but held |
| rd_go | output | 3 | Per-unit operand read permission |
| done | input | 3 | Per-unit completion pulse |
| wr_go | output | 3 | Per-unit write-back permission |
| fu_op | output | 9 | Operation code held for each unit |

## Verification
The assertions assume that the front end keeps presenting a stalled instruction, and that each `done` bit is a one-cycle pulse. Such a pulse arrives only after the unit has been told to read; stray pulses are allowed only to test R6. The bench models each unit as a latency counter that starts on `rd_go`, so completions always follow a read. On top of this it adds deliberate completion pulses aimed at units that are waiting or idle, to show they are ignored. The random instruction stream advances only after a grant. Class-3 instructions are the exception: they are shown for one cycle and then dropped.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NREG  = 8;
    localparam int RW    = $clog2(NREG);
    localparam int NUNIT = 3;
    localparam int UW    = $clog2(NUNIT + 1);
    localparam int NCLS  = 1 << UW;
    localparam int OPW   = 3;

    typedef enum logic [1:0] {
        PH_OPS  = 2'd0,
        PH_EXEC = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic            busy;
        phase_e          ph;
        logic [OPW-1:0]  op;
        logic [RW-1:0]   fi;
        logic [RW-1:0]   fj;
        logic [RW-1:0]   fk;
        logic            qj_v;
        logic            qk_v;
        logic [UW-1:0]   qj;
        logic [UW-1:0]   qk;
        logic            rj;
        logic            rk;
    } fu_ent_t;

    typedef struct packed {
        logic            v;
        logic [UW-1:0]   tag;
    } rstat_t;

    // True when entry e has not yet read and still needs the old value of r.
    function automatic logic needs_old(fu_ent_t e, logic [RW-1:0] r);
        return e.busy && (e.ph == PH_OPS) &&
               (((e.fj == r) && e.rj) || ((e.fk == r) && e.rk));
    endfunction
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
    import sb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic [UW-1:0] set_tag,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    output rstat_t        tab [NREG]
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                tab[r] <= '0;
            end else if (set_en && (set_reg == RW'(r))) begin
                tab[r].v   <= 1'b1;
                tab[r].tag <= set_tag;
            end else if (clr_en && (clr_reg == RW'(r))) begin
                tab[r] <= '0;
            end
        end
    end
endmodule

// File: rtl/sb_issue_gate.sv
module sb_issue_gate
    import sb_pkg::*;
(
    input  logic             in_valid,
    input  logic [UW-1:0]    in_cls,
    input  logic [RW-1:0]    in_dst,
    input  logic [NUNIT-1:0] busy,
    input  logic [NREG-1:0]  pend,
    output logic             grant,
    output logic             stall
);
    logic [NCLS-1:0] occ;

    for (genvar c = 0; c < NCLS; c++) begin : g_occ
        if (c < NUNIT) begin : g_real
            assign occ[c] = busy[c];
        end else begin : g_spare
            assign occ[c] = 1'b1;
        end
    end

    assign grant = in_valid && !occ[in_cls] && !pend[in_dst];
    assign stall = in_valid && !grant;
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
    import sb_pkg::*;
(
    input  fu_ent_t          tbl [NUNIT],
    output logic [NUNIT-1:0] wr_go,
    output logic             wr_any,
    output logic [UW-1:0]    wr_idx,
    output logic [RW-1:0]    wr_reg
);
    logic [NUNIT-1:0] blocked;
    logic [NUNIT-1:0] cand;

    always_comb begin
        for (int w = 0; w < NUNIT; w++) begin
            blocked[w] = 1'b0;
            for (int u = 0; u < NUNIT; u++) begin
                if (u != w) begin
                    blocked[w] = blocked[w] | needs_old(tbl[u], tbl[w].fi);
                end
            end
            cand[w] = tbl[w].busy && (tbl[w].ph == PH_DONE) && !blocked[w];
        end
    end

    assign wr_go  = cand & (~cand + NUNIT'(1));
    assign wr_any = |cand;

    always_comb begin
        wr_idx = '0;
        wr_reg = '0;
        for (int w = NUNIT - 1; w >= 0; w--) begin
            if (wr_go[w]) begin
                wr_idx = UW'(w);
                wr_reg = tbl[w].fi;
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [UW-1:0]        in_cls,
    input  logic [OPW-1:0]       in_op,
    input  logic [RW-1:0]        in_dst,
    input  logic [RW-1:0]        in_src_a,
    input  logic [RW-1:0]        in_src_b,
    output logic                 issue_ok,
    output logic                 issue_stall,
    output logic [NUNIT-1:0]     rd_go,
    input  logic [NUNIT-1:0]     done,
    output logic [NUNIT-1:0]     wr_go,
    output logic [NUNIT*OPW-1:0] fu_op
);
    fu_ent_t          tbl [NUNIT];
    rstat_t           rtab [NREG];
    logic [NUNIT-1:0] busy;
    logic [NREG-1:0]  pend;
    logic             wr_any;
    logic [UW-1:0]    wr_idx;
    logic [RW-1:0]    wr_reg;
    logic             a_wait;
    logic             b_wait;

    for (genvar r = 0; r < NREG; r++) begin : g_pend
        assign pend[r] = rtab[r].v;
    end

    sb_issue_gate u_gate (
        .in_valid (in_valid),
        .in_cls   (in_cls),
        .in_dst   (in_dst),
        .busy     (busy),
        .pend     (pend),
        .grant    (issue_ok),
        .stall    (issue_stall)
    );

    sb_wb_arbiter u_arb (
        .tbl    (tbl),
        .wr_go  (wr_go),
        .wr_any (wr_any),
        .wr_idx (wr_idx),
        .wr_reg (wr_reg)
    );

    sb_regstat u_rstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue_ok),
        .set_reg (in_dst),
        .set_tag (in_cls),
        .clr_en  (wr_any),
        .clr_reg (wr_reg),
        .tab     (rtab)
    );

    // A source whose producer writes back in this very cycle is taken as ready.
    always_comb begin
        a_wait = rtab[in_src_a].v && !(wr_any && (rtab[in_src_a].tag == wr_idx));
        b_wait = rtab[in_src_b].v && !(wr_any && (rtab[in_src_b].tag == wr_idx));
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        assign busy[u]  = tbl[u].busy;
        assign rd_go[u] = tbl[u].busy && (tbl[u].ph == PH_OPS) && tbl[u].rj && tbl[u].rk;
        assign fu_op[u*OPW +: OPW] = tbl[u].op;

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[u] <= '0;
            end else if (wr_go[u]) begin
                tbl[u] <= '0;
            end else if (issue_ok && (in_cls == UW'(u))) begin
                tbl[u].busy <= 1'b1;
                tbl[u].ph   <= PH_OPS;
                tbl[u].op   <= in_op;
                tbl[u].fi   <= in_dst;
                tbl[u].fj   <= in_src_a;
                tbl[u].fk   <= in_src_b;
                tbl[u].qj_v <= a_wait;
                tbl[u].qk_v <= b_wait;
                tbl[u].qj   <= rtab[in_src_a].tag;
                tbl[u].qk   <= rtab[in_src_b].tag;
                tbl[u].rj   <= !a_wait;
                tbl[u].rk   <= !b_wait;
            end else if (tbl[u].busy) begin
                if (rd_go[u]) begin
                    tbl[u].ph <= PH_EXEC;
                    tbl[u].rj <= 1'b0;
                    tbl[u].rk <= 1'b0;
                end else if (done[u] && (tbl[u].ph == PH_EXEC)) begin
                    tbl[u].ph <= PH_DONE;
                end
                if (wr_any && tbl[u].qj_v && (tbl[u].qj == wr_idx)) begin
                    tbl[u].rj   <= 1'b1;
                    tbl[u].qj_v <= 1'b0;
                end
                if (wr_any && tbl[u].qk_v && (tbl[u].qk == wr_idx)) begin
                    tbl[u].rk   <= 1'b1;
                    tbl[u].qk_v <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
    import sb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [UW-1:0]    in_cls,
    input logic [RW-1:0]    in_dst,
    input logic             issue_ok,
    input logic             issue_stall,
    input logic [NUNIT-1:0] rd_go,
    input logic [NUNIT-1:0] wr_go
);
    p_grant_valid_r1: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> in_valid);

    p_stall_meaning_r1: assert property (@(posedge clk) disable iff (rst)
        issue_stall |-> (in_valid && !issue_ok));

    p_unit_taken_r1: assert property (@(posedge clk) disable iff (rst)
        issue_ok |=> !(issue_ok && (in_cls == $past(in_cls))));

    p_waw_block_r2: assert property (@(posedge clk) disable iff (rst)
        issue_ok |=> !(issue_ok && (in_dst == $past(in_dst))));

    p_spare_class_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_cls >= UW'(NUNIT))) |-> !issue_ok);

    p_read_once_r5: assert property (@(posedge clk) disable iff (rst)
        (|rd_go) |=> ((rd_go & $past(rd_go)) == '0));

    p_exec_before_write_r6: assert property (@(posedge clk) disable iff (rst)
        (|rd_go) |=> ((wr_go & $past(rd_go)) == '0));

    p_single_writer_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_go));
endmodule

bind sb_ctrl sb_ctrl_chk chk_i (.*);

// File: tb/sb_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_ctrl_tb_top;
    import sb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [UW-1:0]        in_cls = '0;
    logic [OPW-1:0]       in_op = '0;
    logic [RW-1:0]        in_dst = '0;
    logic [RW-1:0]        in_src_a = '0;
    logic [RW-1:0]        in_src_b = '0;
    logic                 issue_ok;
    logic                 issue_stall;
    logic [NUNIT-1:0]     rd_go;
    logic [NUNIT-1:0]     done = '0;
    logic [NUNIT-1:0]     wr_go;
    logic [NUNIT*OPW-1:0] fu_op;

    always #2.5 clk = ~clk;

    sb_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .issue_ok(issue_ok), .issue_stall(issue_stall), .rd_go(rd_go),
        .done(done), .wr_go(wr_go), .fu_op(fu_op)
    );

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;
    int cyc = 0;

    // bench model of unit and register status
    int m_busy [NUNIT], m_ph [NUNIT], m_dst [NUNIT], m_sa [NUNIT], m_sb [NUNIT];
    int m_ra [NUNIT], m_rb [NUNIT], m_pav [NUNIT], m_pa [NUNIT], m_pbv [NUNIT], m_pb [NUNIT];
    int m_op [NUNIT];
    int p_v [NREG], p_tag [NREG];
    int cnt [NUNIT], lat [NUNIT];
    int first_rd [NUNIT], first_wr [NUNIT];
    bit rnd_lat = 0;
    logic [NUNIT-1:0] inj = '0;

    int d_valid = 0, d_cls = 0, d_op = 0, d_dst = 0, d_sa = 0, d_sb = 0;
    bit g_iss = 0;
    bit g_dut_iss = 0;
    bit g_dut_stall = 0;

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic set_in(int v, int c, int o, int d, int a, int b);
        d_valid = v; d_cls = c; d_op = o; d_dst = d; d_sa = a; d_sb = b;
    endtask

    task automatic step();
        logic [NUNIT-1:0] dv;
        logic [NUNIT-1:0] e_rd, cand, e_wr, dn;
        bit e_iss, wany, blk;
        int widx, na, nb;
        string itag;
        @(negedge clk);
        for (int u = 0; u < NUNIT; u++) begin
            dv[u] = 1'b0;
            if (cnt[u] > 0) begin
                cnt[u]--;
                if (cnt[u] == 0) dv[u] = 1'b1;
            end
        end
        dn = dv | inj;
        done     = dn;
        in_valid = (d_valid != 0);
        in_cls   = UW'(d_cls);
        in_op    = OPW'(d_op);
        in_dst   = RW'(d_dst);
        in_src_a = RW'(d_sa);
        in_src_b = RW'(d_sb);
        #1;
        // expected issue (R1, R2, R3)
        itag = "R1";
        e_iss = (d_valid != 0);
        if (d_cls >= NUNIT) begin
            e_iss = 0; itag = "R3";
        end else begin
            if (m_busy[d_cls] != 0) e_iss = 0;
            if (p_v[d_dst] != 0) begin
                e_iss = 0; if (d_valid != 0 && m_busy[d_cls] == 0) itag = "R2";
            end
        end
        // expected reads (R4) and writes (R7, R9)
        for (int u = 0; u < NUNIT; u++)
            e_rd[u] = (m_busy[u] != 0) && (m_ph[u] == 0) && (m_ra[u] != 0) && (m_rb[u] != 0);
        for (int w = 0; w < NUNIT; w++) begin
            blk = 0;
            for (int u = 0; u < NUNIT; u++)
                if (u != w && m_busy[u] != 0 && m_ph[u] == 0 &&
                    ((m_sa[u] == m_dst[w] && m_ra[u] != 0) || (m_sb[u] == m_dst[w] && m_rb[u] != 0)))
                    blk = 1;
            cand[w] = (m_busy[w] != 0) && (m_ph[w] == 2) && !blk;
        end
        e_wr = '0; wany = 0; widx = 0;
        for (int w = NUNIT - 1; w >= 0; w--)
            if (cand[w]) begin e_wr = '0; e_wr[w] = 1'b1; wany = 1; widx = w; end

        check(itag, int'(issue_ok), int'(e_iss));
        check("R1", int'(issue_stall), int'((d_valid != 0) && !e_iss));
        check("R4", int'(rd_go), int'(e_rd));
        check((|cand && !cand[0]) ? "R7" : "R9", int'(wr_go), int'(e_wr));
        for (int u = 0; u < NUNIT; u++)
            if (m_busy[u] != 0) check("R11", int'(fu_op[u*OPW +: OPW]), m_op[u]);

        g_iss = e_iss; g_dut_iss = issue_ok; g_dut_stall = issue_stall;
        for (int u = 0; u < NUNIT; u++) begin
            if (rd_go[u] && first_rd[u] < 0) first_rd[u] = cyc;
            if (wr_go[u] && first_wr[u] < 0) first_wr[u] = cyc;
        end

        // model update for the coming edge
        na = 0; nb = 0;
        if (e_iss) begin
            na = (p_v[d_sa] != 0) && !(wany && p_tag[d_sa] == widx);
            nb = (p_v[d_sb] != 0) && !(wany && p_tag[d_sb] == widx);
        end
        for (int u = 0; u < NUNIT; u++) begin
            if (m_busy[u] != 0) begin
                if (e_rd[u]) begin m_ph[u] = 1; m_ra[u] = 0; m_rb[u] = 0; end
                else if (dn[u] && m_ph[u] == 1) m_ph[u] = 2;
            end
        end
        if (wany) begin
            for (int u = 0; u < NUNIT; u++) begin
                if (m_pav[u] != 0 && m_pa[u] == widx) begin m_ra[u] = 1; m_pav[u] = 0; end
                if (m_pbv[u] != 0 && m_pb[u] == widx) begin m_rb[u] = 1; m_pbv[u] = 0; end
            end
            p_v[m_dst[widx]] = 0;
            m_busy[widx] = 0;
        end
        if (e_iss) begin
            m_busy[d_cls] = 1; m_ph[d_cls] = 0; m_op[d_cls] = d_op;
            m_dst[d_cls] = d_dst; m_sa[d_cls] = d_sa; m_sb[d_cls] = d_sb;
            m_pav[d_cls] = na; m_pa[d_cls] = p_tag[d_sa]; m_ra[d_cls] = !na;
            m_pbv[d_cls] = nb; m_pb[d_cls] = p_tag[d_sb]; m_rb[d_cls] = !nb;
            p_v[d_dst] = 1; p_tag[d_dst] = d_cls;
        end
        for (int u = 0; u < NUNIT; u++)
            if (e_rd[u]) begin
                if (rnd_lat) lat[u] = 1 + int'($urandom % 6);
                cnt[u] = lat[u];
            end
        cyc++;
    endtask

    task automatic new_inst();
        d_cls = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
        d_op  = int'($urandom % 8);
        d_dst = int'($urandom % NREG);
        d_sa  = int'($urandom % NREG);
        d_sb  = int'($urandom % NREG);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd24681);
        for (int u = 0; u < NUNIT; u++) begin
            m_busy[u] = 0; m_ph[u] = 0; m_dst[u] = 0; m_sa[u] = 0; m_sb[u] = 0;
            m_ra[u] = 0; m_rb[u] = 0; m_pav[u] = 0; m_pa[u] = 0; m_pbv[u] = 0; m_pb[u] = 0;
            m_op[u] = 0; cnt[u] = 0; first_rd[u] = -1; first_wr[u] = -1;
        end
        for (int r = 0; r < NREG; r++) begin p_v[r] = 0; p_tag[r] = 0; end

        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R12", int'(rd_go), 0);
        check("R12", int'(wr_go), 0);
        check("R12", int'(issue_ok), 0);
        rst = 1'b0;

        // directed: long divide, dependent add, multiply overwriting a source of the add
        lat[0] = 2; lat[1] = 2; lat[2] = 10;
        set_in(1, 2, 5, 0, 2, 4); step();                 // c0
        check("R1", int'(g_dut_iss), 1);
        set_in(1, 0, 1, 6, 0, 7); step();                 // c1
        set_in(1, 1, 3, 7, 1, 2); step();                 // c2
        set_in(0, 0, 0, 0, 0, 0); step();                 // c3
        inj = 3'b001; step(); inj = '0;                   // c4: stray completion for waiting add
        for (int k = 5; k <= 15; k++) step();
        set_in(1, 0, 2, 5, 1, 2); step();                 // c16: add unit writes back now
        check("R10", int'(g_dut_iss), 0);
        step();                                           // c17
        check("R10", int'(g_dut_iss), 1);
        set_in(1, 1, 4, 5, 3, 3); step();                 // c18: destination 5 pending
        check("R2", int'(g_dut_stall), 1);
        set_in(1, 3, 0, 6, 0, 0); step();                 // c19: spare class
        check("R3", int'(g_dut_iss), 0);
        set_in(0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) step();

        check("R5", first_rd[1], 3);
        check("R5", first_rd[2], 1);
        check("R7", first_wr[2], 12);
        check("R8", first_rd[0], 13);
        check("R7", first_wr[1], 14);
        check("R6", first_wr[0], 16);

        // random phase
        rnd_lat = 1;
        new_inst();
        for (int k = 0; k < 4000; k++) begin
            if (d_valid != 0 && (g_iss || d_cls == 3)) new_inst();
            d_valid = ($urandom % 4 != 0) ? 1 : 0;
            for (int u = 0; u < NUNIT; u++)
                inj[u] = ($urandom % 20 == 0) && (m_ph[u] != 1 || m_busy[u] == 0);
            step();
        end
        inj = '0;
        d_valid = 0;
        for (int k = 0; k < 80; k++) step();
        for (int u = 0; u < NUNIT; u++) check("R10", m_busy[u], 0);
        finish_run();
    end
endmodule